// File: doc/BRIEF.md
# Routed Local Interrupt Controller

This block gathers 32 peripheral interrupt lines and presents them to four processor cores, each of which has four parent interrupt lines of its own. Every source first passes through a two-flop synchroniser. It is then qualified as level or edge sensitive with a chosen sense, gated by an enable mask and steered by its own route byte. One nibble of the route byte selects the parent line. The other nibble selects the set of cores that see the source.

Software programs the block over a simple 32-bit register bus with byte strobes. The enable mask is changed only through separate write-one-to-set and write-one-to-clear ports, and its current value is read at a third offset. Each core has its own pending-status word. Reading that word also acknowledges any latched edges it shows.

Top module: `route_intc`

## Requirements
- R1: After reset the enable, polarity, edge-select and route registers read zero, and all of `irq_out` is low.
- R2: The route byte of source `s` lives at byte lane `s%4` of the word at offset `4*(s/4)`, in the range 0x00 to 0x1C. Bit `4+n` selects parent line `n` and bit `c` selects core `c`. Each lane is written only when its strobe bit is set, and the whole word reads back.
- R3: Writing to offset 0x28 sets the enable bits that carry a 1 in strobed bytes, and writing to 0x2C clears them. All other bits keep their value. The mask reads back at 0x24, and offsets 0x28 and 0x2C read zero.
- R4: Polarity at 0x30 and edge-select at 0x34 are 32-bit read/write registers with byte strobes.
- R5: A source whose edge-select bit is 0 is pending exactly while its synchronised input differs from its polarity bit. The matching `irq_out` bit follows a change on the input pin after three rising clock edges.
- R6: A source whose edge-select bit is 1 latches a pending bit on a rising edge when its polarity bit is 0, or on a falling edge when it is 1. The latch holds after the input returns. A polarity change alone does not set it. The latch is cleared by a read of a core's status word that shows the source; an edge that arrives in the same cycle wins over the clear.
- R7: `irq_out[4*c+n]` is a registered OR over every source that is enabled, pending, has route bit `4+n` set and has route bit `c` set.
- R8: The status word of core `c` at offset 0x40+8*c shows the enabled, pending sources whose route bit `c` is set. `bus_rdata` is registered: it is valid one edge after `bus_rd` and holds until the next read.
- R9: Offsets outside those listed above (for example 0x20, 0x38, 0x3C, 0x44) read zero, and writes to them change no register and no output.
- R10: A disabled source is absent from every status word and from `irq_out`. An edge it receives while disabled stays latched, the status read does not clear it, and it appears once the source is enabled.
- R11: Setting a source's edge-select bit to 0 discards its latched edge. Setting the bit back to 1 then shows no pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_wstrb | input | 4 | Byte-lane enables for writes |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Registered read data |
| irq_src | input | 32 | Asynchronous peripheral interrupt inputs |
| irq_out | output | 16 | Parent lines, bit 4*core+line |

## Verification
A change on a source pin reaches `irq_out` after exactly three rising edges: two synchroniser flops and the output register. The bench checks that the line is still low after two edges and high after three. A register write changes `irq_out` one edge after the write is captured, so the bench samples one cycle after each write. A status read both returns its data and clears latched edges on the same edge, while the output register still holds the value from before the clear. The bench therefore reads the data at the falling edge after the read, and checks that `irq_out` has dropped one edge later. All sampling happens on falling edges, and all stimulus changes at falling edges.

// File: rtl/intc_pkg.sv
// Shared constants of the routed interrupt controller: bus widths and the
// fixed register offsets. Assumes word-aligned accesses on an 8-bit offset.
package intc_pkg;
    localparam int ADDR_W      = 8;
    localparam int DATA_W      = 32;
    localparam int LANES       = DATA_W / 8;
    localparam logic [ADDR_W-1:0] OFS_ROUTE_TOP = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_EN_VIEW   = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_EN_SET    = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_EN_CLR    = 8'h2C;
    localparam logic [ADDR_W-1:0] OFS_POL       = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_EDGE      = 8'h34;
    localparam logic [ADDR_W-1:0] OFS_STAT_BASE = 8'h40;
    localparam int               STAT_STRIDE   = 8;
endpackage

// File: rtl/intc_sync.sv
// Two-flop synchroniser for a vector of asynchronous inputs.
// Assumes each bit is an independent level; no bus coherency is implied.
module intc_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stage1;

    // Two register stages to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            d_sync <= '0;
        end else begin
            stage1 <= d_async;
            d_sync <= stage1;
        end
    end
endmodule

// File: rtl/intc_trigger.sv
// Per-source trigger qualification: level sense with polarity, or an edge
// latch that sets on the selected edge and clears on acknowledge.
// Assumes sig is already synchronised; set wins over clear in one cycle.
module intc_trigger #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] sig,
    input  logic [NSRC-1:0] pol,
    input  logic [NSRC-1:0] edg,
    input  logic [NSRC-1:0] clr,
    output logic [NSRC-1:0] pending
);
    logic [NSRC-1:0] prev_q;
    logic [NSRC-1:0] latch_q;
    logic [NSRC-1:0] sensed;
    logic [NSRC-1:0] sensed_prev;
    logic [NSRC-1:0] edge_now;

    // Apply polarity to the current and previous samples and detect an edge.
    always_comb begin
        sensed      = sig ^ pol;
        sensed_prev = prev_q ^ pol;
        edge_now    = sensed & ~sensed_prev & edg;
        pending     = (edg & (latch_q | edge_now)) | (~edg & sensed);
    end

    // Keep the previous sample and the edge latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= '0;
            latch_q <= '0;
        end else begin
            prev_q  <= sig;
            latch_q <= ((latch_q & ~clr) | edge_now) & edg;
        end
    end

    AST_LEVEL_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((latch_q & ~$past(edg)) == '0)); // R11
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr != '0) |=> ((latch_q & $past(clr & ~edge_now)) == '0)); // R6
endmodule

// File: rtl/intc_regs.sv
// Register file and bus decode: route bytes, enable set/clear, polarity,
// edge select, per-core status read with edge acknowledge.
// Assumes one access per cycle, word-aligned offsets, NSRC a multiple of 4.
module intc_regs
    import intc_pkg::*;
#(
    parameter int NSRC  = 32,
    parameter int NLINE = 4,
    parameter int NCORE = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [ADDR_W-1:0]                  bus_addr,
    input  logic                               bus_wr,
    input  logic [DATA_W-1:0]                  bus_wdata,
    input  logic [LANES-1:0]                   bus_wstrb,
    input  logic                               bus_rd,
    input  logic [NCORE-1:0][NSRC-1:0]         status_vec,
    output logic [NSRC-1:0][NLINE+NCORE-1:0]   route,
    output logic [NSRC-1:0]                    en,
    output logic [NSRC-1:0]                    pol,
    output logic [NSRC-1:0]                    edg,
    output logic [NSRC-1:0]                    clr,
    output logic [DATA_W-1:0]                  bus_rdata
);
    localparam int RW     = NLINE + NCORE;
    localparam int NWORDS = NSRC / LANES;

    logic [DATA_W-1:0]  bmask;
    logic [NSRC-1:0]    wmask;
    logic [NCORE-1:0]   stat_hit;
    logic [DATA_W-1:0]  rd_word;
    logic [DATA_W-1:0]  route_word [NWORDS];

    // Expand byte strobes into a bit mask.
    always_comb begin
        for (int b = 0; b < LANES; b++) begin
            bmask[b*8 +: 8] = {8{bus_wstrb[b]}};
        end
        wmask = bus_wdata[NSRC-1:0] & bmask[NSRC-1:0];
    end

    // One route byte per source on its own lane.
    for (genvar s = 0; s < NSRC; s++) begin : g_route
        localparam int WORD = s / LANES;
        localparam int LANE = s % LANES;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                route[s] <= '0;
            end else if (bus_wr && bus_wstrb[LANE]
                         && bus_addr == ADDR_W'(WORD * LANES)) begin
                route[s] <= bus_wdata[LANE*8 +: RW];
            end
        end
    end

    // Pack route bytes back into words for reading.
    for (genvar w = 0; w < NWORDS; w++) begin : g_rword
        always_comb begin
            route_word[w] = '0;
            for (int l = 0; l < LANES; l++) begin
                route_word[w][l*8 +: RW] = route[w*LANES + l];
            end
        end
    end

    // Enable mask with set and clear ports; polarity and edge registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en  <= '0;
            pol <= '0;
            edg <= '0;
        end else if (bus_wr) begin
            if (bus_addr == OFS_EN_SET) en <= en | wmask;
            if (bus_addr == OFS_EN_CLR) en <= en & ~wmask;
            if (bus_addr == OFS_POL)    pol <= (pol & ~bmask[NSRC-1:0]) | wmask;
            if (bus_addr == OFS_EDGE)   edg <= (edg & ~bmask[NSRC-1:0]) | wmask;
        end
    end

    // Decode status reads and acknowledge the edges they show.
    always_comb begin
        clr = '0;
        for (int c = 0; c < NCORE; c++) begin
            stat_hit[c] = bus_rd && (bus_addr == ADDR_W'(OFS_STAT_BASE + c * STAT_STRIDE));
            if (stat_hit[c]) clr = clr | status_vec[c];
        end
    end

    // Select the read word; unlisted offsets give zero.
    always_comb begin
        rd_word = '0;
        if (bus_addr <= OFS_ROUTE_TOP && bus_addr[1:0] == 2'b00) begin
            for (int w = 0; w < NWORDS; w++) begin
                if (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(w)) rd_word = route_word[w];
            end
        end
        if (bus_addr == OFS_EN_VIEW) rd_word[NSRC-1:0] = en;
        if (bus_addr == OFS_POL)     rd_word[NSRC-1:0] = pol;
        if (bus_addr == OFS_EDGE)    rd_word[NSRC-1:0] = edg;
        for (int c = 0; c < NCORE; c++) begin
            if (bus_addr == ADDR_W'(OFS_STAT_BASE + c * STAT_STRIDE))
                rd_word[NSRC-1:0] = status_vec[c];
        end
    end

    // Register read data on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_word;
    end

    AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_EN_SET && bus_wstrb == '1)
        |=> ((en & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0]))); // R3
    AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_EN_CLR && bus_wstrb == '1)
        |=> ((en & $past(bus_wdata[NSRC-1:0])) == '0)); // R3
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R8
    AST_ONE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stat_hit)); // R8
endmodule

// File: rtl/intc_fanout.sv
// Combines enable, pending and route bytes into per-core status vectors and
// registered parent lines. Assumes route bits [NLINE+NCORE-1:NCORE] pick lines.
module intc_fanout #(
    parameter int NSRC  = 32,
    parameter int NLINE = 4,
    parameter int NCORE = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NSRC-1:0]                   en,
    input  logic [NSRC-1:0]                   pending,
    input  logic [NSRC-1:0][NLINE+NCORE-1:0]  route,
    output logic [NCORE-1:0][NSRC-1:0]        status_vec,
    output logic [NCORE*NLINE-1:0]            irq_out
);
    logic [NSRC-1:0]        live;
    logic [NCORE*NLINE-1:0] irq_d;

    // Status per core: live sources that name the core.
    always_comb begin
        live = en & pending;
        for (int c = 0; c < NCORE; c++) begin
            for (int s = 0; s < NSRC; s++) begin
                status_vec[c][s] = live[s] & route[s][c];
            end
        end
    end

    // Per core and line, OR the sources that select that line.
    for (genvar c = 0; c < NCORE; c++) begin : g_core
        for (genvar n = 0; n < NLINE; n++) begin : g_line
            always_comb begin
                irq_d[c*NLINE + n] = 1'b0;
                for (int s = 0; s < NSRC; s++) begin
                    irq_d[c*NLINE + n] = irq_d[c*NLINE + n]
                                       | (status_vec[c][s] & route[s][NCORE + n]);
                end
            end
        end
    end

    // Register the parent lines.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_out <= '0;
        else        irq_out <= irq_d;
    end

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out != '0) |-> ($past(en) != '0)); // R7
    AST_IRQ_NEEDS_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out != '0) |-> ($past(route) != '0)); // R7
endmodule

// File: rtl/route_intc.sv
// Top of the routed local interrupt controller: synchroniser, trigger
// qualification, register file and fanout. Assumes a single bus master.
module route_intc #(
    parameter int NSRC  = 32,
    parameter int NLINE = 4,
    parameter int NCORE = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [7:0]             bus_addr,
    input  logic                   bus_wr,
    input  logic [31:0]            bus_wdata,
    input  logic [3:0]             bus_wstrb,
    input  logic                   bus_rd,
    output logic [31:0]            bus_rdata,
    input  logic [NSRC-1:0]        irq_src,
    output logic [NCORE*NLINE-1:0] irq_out
);
    localparam int RW = NLINE + NCORE;

    logic [NSRC-1:0]          src_sync;
    logic [NSRC-1:0]          en, pol, edg, clr, pending;
    logic [NSRC-1:0][RW-1:0]  route;
    logic [NCORE-1:0][NSRC-1:0] status_vec;

    intc_sync #(.W(NSRC)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(irq_src), .d_sync(src_sync)
    );

    intc_trigger #(.NSRC(NSRC)) u_trig (
        .clk(clk), .rst_n(rst_n), .sig(src_sync), .pol(pol), .edg(edg),
        .clr(clr), .pending(pending)
    );

    intc_regs #(.NSRC(NSRC), .NLINE(NLINE), .NCORE(NCORE)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_wstrb(bus_wstrb), .bus_rd(bus_rd),
        .status_vec(status_vec), .route(route), .en(en), .pol(pol),
        .edg(edg), .clr(clr), .bus_rdata(bus_rdata)
    );

    intc_fanout #(.NSRC(NSRC), .NLINE(NLINE), .NCORE(NCORE)) u_fan (
        .clk(clk), .rst_n(rst_n), .en(en), .pending(pending), .route(route),
        .status_vec(status_vec), .irq_out(irq_out)
    );
endmodule

// File: tb/tb_route_intc.sv
module tb_route_intc;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_wstrb = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [31:0] irq_src = '0;
    logic [15:0] irq_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    route_intc dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_wstrb(bus_wstrb), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .irq_src(irq_src), .irq_out(irq_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
        bus_addr = a; bus_wdata = d; bus_wstrb = s; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; bus_wstrb = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(8'h24, d); check("R1", "enable after reset", d, 32'h0);
        rd(8'h30, d); check("R1", "polarity after reset", d, 32'h0);
        rd(8'h34, d); check("R1", "edge after reset", d, 32'h0);
        rd(8'h00, d); check("R1", "route word after reset", d, 32'h0);
        check("R1", "irq_out after reset", {16'h0, irq_out}, 32'h0);
    endtask

    task automatic t_route;
        logic [31:0] d;
        wr(8'h04, 32'hFFFF_A5FF, 4'b0010);
        rd(8'h04, d); check("R2", "single lane write", d, 32'h0000_A500);
        wr(8'h1C, 32'h1122_3344, 4'hF);
        rd(8'h1C, d); check("R2", "full word write", d, 32'h1122_3344);
    endtask

    task automatic t_enable;
        logic [31:0] d;
        wr(8'h28, 32'h0000_00F0, 4'hF);
        rd(8'h24, d); check("R3", "set bits", d, 32'h0000_00F0);
        wr(8'h2C, 32'h0000_0030, 4'hF);
        rd(8'h24, d); check("R3", "clear bits", d, 32'h0000_00C0);
        wr(8'h28, 32'hFFFF_FF0F, 4'b0001);
        rd(8'h24, d); check("R3", "strobed set", d, 32'h0000_00CF);
        rd(8'h28, d); check("R3", "set port reads zero", d, 32'h0);
        rd(8'h2C, d); check("R3", "clear port reads zero", d, 32'h0);
        wr(8'h2C, 32'hFFFF_FFFF, 4'hF);
    endtask

    task automatic t_polreg;
        logic [31:0] d;
        wr(8'h30, 32'hDEAD_BEEF, 4'b0101);
        rd(8'h30, d); check("R4", "polarity strobed", d, 32'h00AD_00EF);
        wr(8'h34, 32'h1234_5678, 4'hF);
        rd(8'h34, d); check("R4", "edge full", d, 32'h1234_5678);
        wr(8'h30, 32'h0, 4'hF);
        wr(8'h34, 32'h0, 4'hF);
    endtask

    task automatic t_level;
        logic [31:0] d;
        wr(8'h04, 32'h0000_4200, 4'b0010);   // src5: line2, core1
        wr(8'h28, 32'h0000_0020, 4'hF);
        irq_src[5] = 1'b1;
        step(2); check("R5", "level not yet out after 2 edges", {16'h0, irq_out}, 32'h0);
        step(1); check("R7", "level out after 3 edges", {16'h0, irq_out}, 32'h0040);
        rd(8'h48, d); check("R8", "core1 status", d, 32'h0000_0020);
        rd(8'h40, d); check("R8", "core0 status", d, 32'h0);
        irq_src[5] = 1'b0;
        step(3); check("R5", "level release", {16'h0, irq_out}, 32'h0);
        wr(8'h30, 32'h0000_0020, 4'hF);
        step(1); check("R5", "active low asserts", {16'h0, irq_out}, 32'h0040);
        wr(8'h30, 32'h0, 4'hF);
        step(1); check("R5", "active high idle", {16'h0, irq_out}, 32'h0);
    endtask

    task automatic t_edge;
        logic [31:0] d;
        wr(8'h08, 32'h0000_1900, 4'b0010);   // src9: line0, cores 0 and 3
        wr(8'h34, 32'h0000_0200, 4'hF);
        wr(8'h28, 32'h0000_0200, 4'hF);
        irq_src[9] = 1'b1;
        step(3); check("R6", "rising edge out", {16'h0, irq_out}, 32'h1001);
        irq_src[9] = 1'b0;
        step(3); check("R6", "edge held after release", {16'h0, irq_out}, 32'h1001);
        rd(8'h40, d); check("R6", "core0 status shows edge", d, 32'h0000_0200);
        step(1); check("R6", "read acknowledges edge", {16'h0, irq_out}, 32'h0);
        rd(8'h40, d); check("R6", "status empty after ack", d, 32'h0);
        wr(8'h30, 32'h0000_0200, 4'hF);
        step(1); check("R6", "polarity change alone no edge", {16'h0, irq_out}, 32'h0);
        irq_src[9] = 1'b1;
        step(3); check("R6", "rising ignored when falling selected", {16'h0, irq_out}, 32'h0);
        irq_src[9] = 1'b0;
        step(3); check("R6", "falling edge out", {16'h0, irq_out}, 32'h1001);
        rd(8'h58, d); check("R6", "core3 status shows edge", d, 32'h0000_0200);
        step(1); check("R6", "core3 read acknowledges", {16'h0, irq_out}, 32'h0);
        wr(8'h30, 32'h0, 4'hF);
    endtask

    task automatic t_disabled;
        logic [31:0] d;
        wr(8'h2C, 32'h0000_0200, 4'hF);
        irq_src[9] = 1'b1;
        step(3);
        irq_src[9] = 1'b0;
        step(3); check("R10", "disabled edge not out", {16'h0, irq_out}, 32'h0);
        rd(8'h40, d); check("R10", "disabled not in status", d, 32'h0);
        wr(8'h28, 32'h0000_0200, 4'hF);
        step(1); check("R10", "held edge appears on enable", {16'h0, irq_out}, 32'h1001);
        wr(8'h34, 32'h0, 4'hF);
        step(1); check("R11", "level mode drops edge", {16'h0, irq_out}, 32'h0);
        wr(8'h34, 32'h0000_0200, 4'hF);
        step(1); check("R11", "latch discarded", {16'h0, irq_out}, 32'h0);
        wr(8'h2C, 32'hFFFF_FFFF, 4'hF);
        wr(8'h34, 32'h0, 4'hF);
    endtask

    task automatic t_multi;
        logic [31:0] d;
        wr(8'h1C, 32'h8400_0000, 4'b1000);   // src31: line3, core2
        wr(8'h28, 32'h8000_0020, 4'hF);
        irq_src[5] = 1'b1; irq_src[31] = 1'b1;
        step(3); check("R7", "two sources two lines", {16'h0, irq_out}, 32'h0840);
        rd(8'h50, d); check("R8", "core2 status", d, 32'h8000_0000);
        irq_src[5] = 1'b0;
        step(3); check("R7", "one source left", {16'h0, irq_out}, 32'h0800);
    endtask

    task automatic t_unmapped;
        logic [31:0] d;
        wr(8'h20, 32'hFFFF_FFFF, 4'hF);
        wr(8'h38, 32'hFFFF_FFFF, 4'hF);
        wr(8'h3C, 32'hFFFF_FFFF, 4'hF);
        wr(8'h44, 32'hFFFF_FFFF, 4'hF);
        rd(8'h20, d); check("R9", "0x20 reads zero", d, 32'h0);
        rd(8'h38, d); check("R9", "0x38 reads zero", d, 32'h0);
        rd(8'h44, d); check("R9", "0x44 reads zero", d, 32'h0);
        rd(8'h24, d); check("R9", "enable untouched", d, 32'h8000_0020);
        rd(8'h34, d); check("R9", "edge untouched", d, 32'h0);
        check("R9", "irq untouched", {16'h0, irq_out}, 32'h0800);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        step(1);
        t_reset;
        t_route;
        t_enable;
        t_polreg;
        t_level;
        t_edge;
        t_disabled;
        t_multi;
        t_unmapped;
        done = 1'b1;
        summary;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            summary;
        end
    end
endmodule